// File: doc/BRIEF.md
# Hybrid-Reduction Digit-Serial Binary Field Multiplier

This block multiplies two elements of a binary polynomial field GF(2^m) and returns the product reduced modulo the field polynomial. Its operand registers are 256 bits wide, so any degree m up to 255 can be served. Because there are no carries in GF(2^m), partial products are combined with XOR. The multiplier operand is consumed one digit at a time, starting with the most significant digit. Each cycle the double-length accumulator is shifted left by one digit and the product of the multiplicand with that digit is XORed in.

Two reduction paths are available, chosen per operation.

- **Named mode.** The field is fixed at degree 163 with polynomial x^163 + x^7 + x^6 + x^3 + 1. Bits at or above degree 163 are folded down by a dedicated XOR network, one fold per cycle.
- **Generic mode.** The caller supplies m and the lower terms g of the field polynomial at run time. The high part H of the product is sent back through the same digit-serial datapath as H·g, and the result is XORed into the low part. This repeats until nothing remains at or above degree m.

A start/busy/done handshake controls the block.

Top module: `gf2m_hybrid_mul`

## Requirements
- R1: With `generic_mode`=0 the result equals a·b mod (x^163 + x^7 + x^6 + x^3 + 1), for operands with no bits at or above position 163.
- R2: With `generic_mode`=1 the result equals a·b mod (x^m + g), where bit i of `poly` is the coefficient of x^i in g. This holds for any m from 2 to 255 when a, b and `poly` have no bits at or above position m.
- R3: On every `done`, all `result` bits at or above the field degree are zero (degree 163 in named mode, m in generic mode).
- R4: `start` is accepted only while `busy` is low. A `start` raised while busy is ignored, and the operands, mode, m and `poly` captured at acceptance are used.
- R5: `busy` is high in the cycle after an accepted `start`. `done` is high for exactly one cycle. `busy` is already low in the cycle `done` is high.
- R6: `result` changes only in a cycle where `done` is high and holds its value otherwise.
- R7: In named mode the `m` input has no effect on the result.
- R8: After reset, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled while idle) |
| generic_mode | input | 1 | 0: fixed degree-163 field, 1: run-time field |
| m | input | 8 | Field degree for generic mode (2..255) |
| poly | input | 256 | Field polynomial without its x^m term |
| a | input | 256 | Multiplicand |
| b | input | 256 | Multiplier, consumed one digit per cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 256 | Reduced product |

## Verification
Small generic fields (m = 3 and m = 4) are swept exhaustively over every operand pair. This exposes digit-order, XOR-accumulation and mask errors on every bit combination.

Generic mode is also tried at degrees on and around digit boundaries (15, 16, 17, 31, 33, 64, 128) and at the extremes 2, 254 and 255. Sparse trinomials need only a couple of reduction passes, while dense random polynomials force many passes and separate the iteration and termination logic from the single-pass case.

Named mode is run with random operands, all-ones operands and top-degree operands, each with a garbage `m`. These cases exercise both folds of the fixed network and show that `m` is ignored. Some operations also receive a second `start` with different inputs while busy, which would corrupt the result if it were accepted.

// File: rtl/gf2m_hybrid_mul.sv
module gf2m_hybrid_mul #(
  parameter int W = 256,
  parameter int D = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 generic_mode,
  input  logic [$clog2(W)-1:0] m,
  input  logic [W-1:0]         poly,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  output logic                 busy,
  output logic                 done,
  output logic [W-1:0]         result
);
  localparam int MW      = $clog2(W);
  localparam int PW      = 2 * W;
  localparam int NDIG    = W / D;
  localparam int CW      = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam int NAMED_M = 163;

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_RED} st_t;

  st_t            st;
  logic           mode_r;
  logic [MW-1:0]  m_r;
  logic [W-1:0]   poly_r, mcand, mplier;
  logic [PW-1:0]  acc, low;
  logic [CW-1:0]  cnt, cnt_top;

  logic [MW-1:0]  m_in;
  logic [CW-1:0]  top_in;
  logic [D-1:0]   digit;
  logic [PW-1:0]  pp, acc_next, mask_m, hi_g, lo_g, hi_n, fold_n;

  assign busy   = (st != S_IDLE);
  assign m_in   = generic_mode ? m : MW'(NAMED_M);
  assign top_in = CW'((int'(m_in) + D - 1) / D - 1);
  assign digit  = mplier[cnt*D +: D];

  always_comb begin
    pp = '0;
    for (int i = 0; i < D; i++)
      if (digit[i]) pp = pp ^ (PW'(mcand) << i);
  end

  assign acc_next = (acc << D) ^ pp;
  assign mask_m   = (PW'(1) << m_r) - PW'(1);
  assign hi_g     = acc >> m_r;
  assign lo_g     = acc & mask_m;
  assign hi_n     = acc >> NAMED_M;
  assign fold_n   = lo_g ^ hi_n ^ (hi_n << 3) ^ (hi_n << 6) ^ (hi_n << 7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      mode_r  <= 1'b0;
      m_r     <= MW'(NAMED_M);
      poly_r  <= '0;
      mcand   <= '0;
      mplier  <= '0;
      acc     <= '0;
      low     <= '0;
      cnt     <= '0;
      cnt_top <= '0;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mode_r  <= generic_mode;
          m_r     <= m_in;
          poly_r  <= poly;
          mcand   <= a;
          mplier  <= b;
          acc     <= '0;
          low     <= '0;
          cnt     <= top_in;
          cnt_top <= top_in;
          st      <= S_MUL;
        end
        S_MUL: begin
          cnt <= cnt - CW'(1);
          if (cnt == '0) begin
            acc <= acc_next ^ low;
            st  <= S_RED;
          end else begin
            acc <= acc_next;
          end
        end
        S_RED: begin
          if (hi_g == '0) begin
            result <= acc[W-1:0];
            done   <= 1'b1;
            st     <= S_IDLE;
          end else if (!mode_r) begin
            acc <= fold_n;
          end else begin
            mcand  <= poly_r;
            mplier <= hi_g[W-1:0];
            low    <= lo_g;
            acc    <= '0;
            cnt    <= cnt_top;
            st     <= S_MUL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gf2m_hybrid_mul_chk.sv
module gf2m_hybrid_mul_chk #(
  parameter int W  = 256,
  parameter int MW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [W-1:0]  result,
  input logic [MW-1:0] m_r,
  input logic          mode_r
);
  AST_RESULT_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((result >> m_r) == '0)); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R4
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(m_r) && $stable(mode_r))); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R6
  AST_NAMED_DEGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_r) |-> (m_r == MW'(163))); // R7
endmodule

bind gf2m_hybrid_mul gf2m_hybrid_mul_chk #(.W(W), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .result(result), .m_r(m_r), .mode_r(mode_r)
);

// File: tb/tb_gf2m_hybrid_mul.sv
`timescale 1ns/1ps
module tb_gf2m_hybrid_mul;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         generic_mode = 1'b0;
  logic [7:0]   m = 8'd0;
  logic [255:0] poly = '0, a = '0, b = '0;
  logic         busy, done;
  logic [255:0] result;

  int checks = 0;
  int errors = 0;
  localparam logic [255:0] NAMED_G = 256'hC9;

  always #2.5 clk = ~clk;

  gf2m_hybrid_mul dut (
    .clk(clk), .rst_n(rst_n), .start(start), .generic_mode(generic_mode),
    .m(m), .poly(poly), .a(a), .b(b), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [255:0] msk(input int mm);
    return (256'd1 << mm) - 256'd1;
  endfunction

  function automatic logic [255:0] rnd(input int mm);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v & msk(mm);
  endfunction

  function automatic logic [255:0] ref_mm(input logic [255:0] x, input logic [255:0] y,
                                          input int mm, input logic [255:0] g);
    logic [255:0] p;
    logic top;
    p = '0;
    for (int i = mm - 1; i >= 0; i--) begin
      top = p[mm-1];
      p = (p << 1) & msk(mm);
      if (top) p = p ^ g;
      if (y[i]) p = p ^ x;
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string rq, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run_op(input logic [255:0] ta, input logic [255:0] tb_, input bit gm,
                        input int tm, input logic [255:0] tg, input bit poke,
                        input string rq);
    logic [255:0] exp, r;
    int n;
    exp = gm ? ref_mm(ta, tb_, tm, tg) : ref_mm(ta, tb_, 163, NAMED_G);
    @(negedge clk);
    a = ta; b = tb_; generic_mode = gm; m = 8'(tm); poly = tg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R5 busy after start", 256'(busy), 256'd1);
    if (poke) begin
      a = ~ta; b = ~tb_; m = 8'(tm - 1); poly = ~tg; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (done !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done === 1'b1, "R5 done timeout", 256'(done), 256'd1);
    check(result === exp, rq, result, exp);
    check(busy === 1'b0, "R5 busy low with done", 256'(busy), 256'd0);
    r = result;
    @(negedge clk);
    check(done === 1'b0, "R5 done single cycle", 256'(done), 256'd0);
    check(result === r, "R6 result held", result, r);
  endtask

  initial begin
    #(5.0 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ms[15] = '{2, 5, 8, 15, 16, 17, 31, 33, 64, 100, 128, 163, 200, 254, 255};
    logic [255:0] g;
    int k;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R8 reset flags", {busy, done}, 256'd0);
    check(result === '0, "R8 reset result", result, 256'd0);
    rst_n = 1'b1;

    // R2 exhaustive m=4 (x^4+x+1) and m=3 (x^3+x+1)
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        run_op(256'(x), 256'(y), 1'b1, 4, 256'h3, 1'b0, "R2 m=4 sweep");
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++)
        run_op(256'(x), 256'(y), 1'b1, 3, 256'h3, 1'b0, "R2 m=3 sweep");

    // R2/R3 degree sweep: trinomials and dense polynomials
    foreach (ms[j]) begin
      k = ms[j] / 2;
      if (k == 0) k = 1;
      g = (256'd1 << k) | 256'd1;
      for (int t = 0; t < 3; t++)
        run_op(rnd(ms[j]), rnd(ms[j]), 1'b1, ms[j], g, t == 1, "R2 trinomial");
      g = rnd(ms[j]) | 256'd1;
      run_op(rnd(ms[j]), rnd(ms[j]), 1'b1, ms[j], g, 1'b0, "R2 dense poly");
      run_op(msk(ms[j]), msk(ms[j]), 1'b1, ms[j], g, 1'b0, "R3 all ones");
    end

    // R1/R7 named field with a garbage m input
    for (int t = 0; t < 12; t++)
      run_op(rnd(163), rnd(163), 1'b0, 7 + t * 17, '0, t % 3 == 0, "R1 R7 named random");
    run_op(msk(163), msk(163), 1'b0, 40, '0, 1'b0, "R1 named all ones");
    run_op(256'd1 << 162, 256'd1 << 162, 1'b0, 255, '0, 1'b0, "R1 named top degree");
    run_op(256'd1, msk(163), 1'b0, 2, '0, 1'b1, "R1 R4 named unit");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule